// File: doc/BRIEF.md
# PRBS Stimulus Generator

This block is the pattern source of a bit-error-rate tester transmitter. Each enabled clock cycle it emits one parallel word of a pseudo-random test stream. The stream comes from one of six maximal-length shift-register polynomials. The word is shaped in one of three ways: plain, with a long zero run stamped once per sequence period, or with its density of ones moved away from one half. Its polarity can be inverted at the output.

An error injector can invert single bits of the stream. It acts on a software request pulse, on each rising edge of an external strobe, or on a fixed schedule of one error every 10^n bits. A downstream serializer sends the word MSB first. A change of polynomial, shaping mode or density restarts the sequence from its seed, so a receiver can resynchronise without help.

Top module: `prbs_stim_gen`

## Requirements
- R1: `poly_sel` picks the polynomial: 0 = x^31+x^28+1, 1 = x^23+x^18+1, 2 = x^15+x^14+1, 3 = x^11+x^9+1, 4 = x^10+x^7+1, 5 = x^7+x^6+1 (6 and 7 act as 0).
  - For x^N+x^T+1 the register holds N bits and starts all ones.
  - Each step forms a new bit as reg[N-1] XOR reg[T-1] and shifts that bit in at reg[0].
  - Bit i of the stream is the complement of the i-th new bit, so the stream repeats every 2^N-1 bits and holds 2^(N-1)-1 ones per period.
  - `data_out[WORD_W-1]` carries the earliest bit of a word.
- R2: With `out_inv`=1 every emitted bit is the complement of the bit emitted with `out_inv`=0.
- R3: Reset behaviour:
  - While `rst_n` is low, `data_valid` and `data_out` are 0.
  - A change of `poly_sel`, `mode_sel` or `dens_sel` produces one cycle without a valid word.
  - After reset or such a restart, the stream restarts from its first bit.
- R4: Enable behaviour:
  - A word appears, with `data_valid`=1, one cycle after each enabled, non-restart cycle.
  - After a cycle with `gen_en`=0, `data_valid` is 0 and `data_out` holds its value.
  - No bit of the sequence is skipped across such stalls.
- R5: `mode_sel`=1 (zero substitution) overwrites with zeros the `zrun_len` bits that start at each bit made while the N-bit register holds all ones, that is at stream bits 0, 2^N-1, and so on. `zrun_len` ranges from 1 to 2^N-2 and 0 disables the substitution. The shift register keeps stepping under the overwritten bits.
- R6: In zero substitution mode the bit right after each substituted run is 1.
- R7: `mode_sel`=2 (mark density) builds output bit j from stream bits k*j to k*j+k-1:
  - `dens_sel` 0 = AND of 3 (1/8), 1 = AND of 2 (1/4), 2 = the bit itself (1/2), 3 = OR of 2 (3/4), 4 = OR of 3 (7/8); other codes act as 2.
  - Over 127 words of the 7-bit polynomial with 16-bit words, the output holds 240, 496, 1008, 1520 and 1776 ones respectively.
- R8: With `ratio_en`=1 bit number 10^(ratio_sel+3)*m - 1 (m = 1, 2, ...) after a restart is inverted, counting from 0 over emitted bits. `ratio_sel` values above 6 act as 6.
- R9: A high `sw_inject`, or a rising edge of `ext_strobe` (sampled on `clk`), inverts the earliest bit of the word made in that cycle. A request that arrives while no word is made is held for the next word.
- R10: A word carries at most one injected error. Requests that meet in one word merge, and a ratio error in that word takes the place of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gen_en | input | 1 | Produce a word this cycle |
| poly_sel | input | 3 | Polynomial select |
| mode_sel | input | 2 | 0 plain, 1 zero substitution, 2 mark density, 3 plain |
| dens_sel | input | 3 | Mark density select |
| zrun_len | input | 32 | Length of the substituted zero run |
| out_inv | input | 1 | Invert output polarity |
| ratio_en | input | 1 | Enable fixed-ratio error insertion |
| ratio_sel | input | 3 | Ratio exponent minus 3 |
| sw_inject | input | 1 | Single error request |
| ext_strobe | input | 1 | External error strobe, one error per rising edge |
| data_out | output | WORD_W | Pattern word, earliest bit in the MSB |
| data_valid | output | 1 | data_out holds a new word |

## Verification
A wrong tap, seed or shift order in the register corrupts the stream. The first word after reset already differs from a model of the polynomial, and a wrong period shows as a mismatch between a bit and the bit one period later. Faults in the zero-run counter or the density combiner appear as wrong run lengths or ones counts within the first one or two periods. A fault in the ratio counter moves an inverted bit away from its exact scheduled index within the first thousand bits. Injection and stall faults appear in the very next word.

// File: rtl/prbs_stim_pkg.sv
package prbs_stim_pkg;

   localparam int LFSR_W  = 31;
   localparam int MAX_K   = 3;
   localparam int CFG_W   = 8;

   typedef enum logic [1:0] {
      MODE_PLAIN = 2'd0,
      MODE_ZSUB  = 2'd1,
      MODE_DENS  = 2'd2,
      MODE_ALT   = 2'd3
   } mode_e;

   // highest register index used by each polynomial (N-1)
   function automatic logic [4:0] poly_len_m1(input logic [2:0] sel);
      case (sel)
         3'd1:    return 5'd22;
         3'd2:    return 5'd14;
         3'd3:    return 5'd10;
         3'd4:    return 5'd9;
         3'd5:    return 5'd6;
         default: return 5'd30;
      endcase
   endfunction

   // inner tap index (T-1)
   function automatic logic [4:0] poly_tap_m1(input logic [2:0] sel);
      case (sel)
         3'd1:    return 5'd17;
         3'd2:    return 5'd13;
         3'd3:    return 5'd8;
         3'd4:    return 5'd6;
         3'd5:    return 5'd5;
         default: return 5'd27;
      endcase
   endfunction

   function automatic logic [LFSR_W-1:0] poly_mask(input logic [2:0] sel);
      logic [LFSR_W-1:0] m;
      for (int i = 0; i < LFSR_W; i++)
         m[i] = (i <= int'(poly_len_m1(sel)));
      return m;
   endfunction

   // number of LFSR bits consumed per output bit
   function automatic logic [1:0] dens_step(input logic [2:0] d);
      case (d)
         3'd0, 3'd4: return 2'd3;
         3'd1, 3'd3: return 2'd2;
         default:    return 2'd1;
      endcase
   endfunction

   // bits between fixed-ratio errors: 10^(sel+3)
   function automatic logic [31:0] ratio_period(input logic [2:0] sel);
      logic [31:0] v;
      int n;
      v = 32'd1000;
      n = (sel > 3'd6) ? 6 : int'(sel);
      for (int i = 0; i < 6; i++)
         if (i < n) v = v * 32'd10;
      return v;
   endfunction

endpackage

// File: rtl/prbs_lfsr_core.sv
module prbs_lfsr_core
   import prbs_stim_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [2:0]                poly_sel,
   input  logic                      reseed,
   input  logic                      advance,
   input  logic [1:0]                k_sel,
   output logic [MAX_K*WORD_W-1:0]   std_bits,
   output logic [WORD_W-1:0]         marks,
   output logic [LFSR_W-1:0]         state_q
);

   localparam int CHAIN = MAX_K * WORD_W;
   localparam logic [LFSR_W-1:0] SEED = '1;

   logic [4:0]              len_m1;
   logic [4:0]              tap_m1;
   logic [LFSR_W-1:0]       mask;
   logic [CHAIN:0][LFSR_W-1:0] st;
   logic [CHAIN-1:0]        fb;
   logic [LFSR_W-1:0]       state_d;

   assign len_m1 = poly_len_m1(poly_sel);
   assign tap_m1 = poly_tap_m1(poly_sel);
   assign mask   = poly_mask(poly_sel);
   assign st[0]  = state_q;

   // one unrolled shift step per stream bit
   genvar i;
   for (i = 0; i < CHAIN; i++) begin : g_step
      assign fb[i]       = st[i][len_m1] ^ st[i][tap_m1];
      assign st[i+1]     = {st[i][LFSR_W-2:0], fb[i]};
      assign std_bits[i] = ~fb[i];
      if (i < WORD_W) begin : g_mark
         assign marks[i] = ((st[i] & mask) == mask);
      end
   end

   always_comb begin
      case (k_sel)
         2'd2:    state_d = st[2*WORD_W];
         2'd3:    state_d = st[3*WORD_W];
         default: state_d = st[WORD_W];
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       state_q <= SEED;
      else if (reseed)  state_q <= SEED;
      else if (advance) state_q <= state_d;
   end

endmodule

// File: rtl/prbs_shaper.sv
module prbs_shaper
   import prbs_stim_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [1:0]                mode_sel,
   input  logic [2:0]                dens_sel,
   input  logic [31:0]               zrun_len,
   input  logic                      restart,
   input  logic                      advance,
   input  logic [MAX_K*WORD_W-1:0]   std_bits,
   input  logic [WORD_W-1:0]         marks,
   output logic [1:0]                k_sel,
   output logic [WORD_W-1:0]         shaped
);

   logic [WORD_W-1:0] and3, and2, or2, or3, dens_bits, zs_bits;
   logic [31:0]       zcnt_q, zcnt_d;
   logic              zf_q, zf_d;
   logic              is_dens, is_zsub;

   assign is_dens = (mode_sel == MODE_DENS);
   assign is_zsub = (mode_sel == MODE_ZSUB);
   assign k_sel   = is_dens ? dens_step(dens_sel) : 2'd1;

   genvar j;
   for (j = 0; j < WORD_W; j++) begin : g_comb
      assign and3[j] = std_bits[3*j] & std_bits[3*j+1] & std_bits[3*j+2];
      assign or3[j]  = std_bits[3*j] | std_bits[3*j+1] | std_bits[3*j+2];
      assign and2[j] = std_bits[2*j] & std_bits[2*j+1];
      assign or2[j]  = std_bits[2*j] | std_bits[2*j+1];
   end

   always_comb begin
      case (dens_sel)
         3'd0:    dens_bits = and3;
         3'd1:    dens_bits = and2;
         3'd3:    dens_bits = or2;
         3'd4:    dens_bits = or3;
         default: dens_bits = std_bits[WORD_W-1:0];
      endcase
   end

   // zero-run substitution, walked bit by bit in stream order
   always_comb begin
      logic [31:0] c;
      logic        f;
      c       = zcnt_q;
      f       = zf_q;
      zs_bits = '0;
      for (int b = 0; b < WORD_W; b++) begin
         if (marks[b] && (c == 32'd0) && !f && (zrun_len != 32'd0))
            c = zrun_len;
         if (c != 32'd0) begin
            zs_bits[b] = 1'b0;
            c          = c - 32'd1;
            f          = (c == 32'd0);
         end else if (f) begin
            zs_bits[b] = 1'b1;
            f          = 1'b0;
         end else begin
            zs_bits[b] = std_bits[b];
         end
      end
      zcnt_d = c;
      zf_d   = f;
   end

   always_comb begin
      if (is_dens)      shaped = dens_bits;
      else if (is_zsub) shaped = zs_bits;
      else              shaped = std_bits[WORD_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         zcnt_q <= '0;
         zf_q   <= 1'b0;
      end else if (restart) begin
         zcnt_q <= '0;
         zf_q   <= 1'b0;
      end else if (advance && is_zsub) begin
         zcnt_q <= zcnt_d;
         zf_q   <= zf_d;
      end
   end

endmodule

// File: rtl/prbs_err_inject.sv
module prbs_err_inject
   import prbs_stim_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              advance,
   input  logic              ratio_en,
   input  logic [2:0]        ratio_sel,
   input  logic              sw_inject,
   input  logic              ext_strobe,
   output logic [WORD_W-1:0] flip_mask
);

   localparam logic [31:0] STEP = 32'(WORD_W);

   logic        ext_q, pend_q, req, hit;
   logic [31:0] thr, rcnt_q, sum, pos;

   assign req = sw_inject | (ext_strobe & ~ext_q) | pend_q;
   assign thr = ratio_period(ratio_sel);
   assign sum = rcnt_q + STEP;
   assign hit = ratio_en && (sum >= thr);
   assign pos = thr - rcnt_q - 32'd1;

   always_comb begin
      flip_mask = '0;
      for (int b = 0; b < WORD_W; b++) begin
         if (hit) flip_mask[b] = (pos == 32'(b));
      end
      if (!hit && req) flip_mask[0] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_q  <= 1'b0;
         pend_q <= 1'b0;
         rcnt_q <= '0;
      end else begin
         ext_q  <= ext_strobe;
         pend_q <= advance ? 1'b0 : req;
         if (restart)       rcnt_q <= '0;
         else if (advance)  rcnt_q <= !ratio_en ? 32'd0 : (hit ? sum - thr : sum);
      end
   end

endmodule

// File: rtl/prbs_stim_gen.sv
module prbs_stim_gen
   import prbs_stim_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gen_en,
   input  logic [2:0]        poly_sel,
   input  logic [1:0]        mode_sel,
   input  logic [2:0]        dens_sel,
   input  logic [31:0]       zrun_len,
   input  logic              out_inv,
   input  logic              ratio_en,
   input  logic [2:0]        ratio_sel,
   input  logic              sw_inject,
   input  logic              ext_strobe,
   output logic [WORD_W-1:0] data_out,
   output logic              data_valid
);

   if (WORD_W < 2 || WORD_W > 64) begin : g_bad_width
      $error("prbs_stim_gen: WORD_W must lie in 2..64");
   end

   logic [CFG_W-1:0]        cfg_now, cfg_q;
   logic                    restart, advance;
   logic [1:0]              k_sel;
   logic [MAX_K*WORD_W-1:0] std_bits;
   logic [WORD_W-1:0]       marks, shaped, flip_mask, word_t, word_o;
   logic [LFSR_W-1:0]       lfsr_state;

   assign cfg_now = {poly_sel, mode_sel, dens_sel};
   assign restart = (cfg_now != cfg_q);
   assign advance = gen_en & ~restart;

   prbs_lfsr_core #(.WORD_W(WORD_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .poly_sel (poly_sel),
      .reseed   (restart),
      .advance  (advance),
      .k_sel    (k_sel),
      .std_bits (std_bits),
      .marks    (marks),
      .state_q  (lfsr_state)
   );

   prbs_shaper #(.WORD_W(WORD_W)) u_shape (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_sel (mode_sel),
      .dens_sel (dens_sel),
      .zrun_len (zrun_len),
      .restart  (restart),
      .advance  (advance),
      .std_bits (std_bits),
      .marks    (marks),
      .k_sel    (k_sel),
      .shaped   (shaped)
   );

   prbs_err_inject #(.WORD_W(WORD_W)) u_err (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (restart),
      .advance    (advance),
      .ratio_en   (ratio_en),
      .ratio_sel  (ratio_sel),
      .sw_inject  (sw_inject),
      .ext_strobe (ext_strobe),
      .flip_mask  (flip_mask)
   );

   assign word_t = shaped ^ flip_mask ^ {WORD_W{out_inv}};

   // stream order index 0 leaves first, on the MSB
   genvar g;
   for (g = 0; g < WORD_W; g++) begin : g_order
      assign word_o[WORD_W-1-g] = word_t[g];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q      <= '0;
         data_out   <= '0;
         data_valid <= 1'b0;
      end else begin
         cfg_q      <= cfg_now;
         data_valid <= advance;
         if (advance) data_out <= word_o;
      end
   end

endmodule

// File: rtl/prbs_stim_chk.sv
module prbs_stim_chk
   import prbs_stim_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              gen_en,
   input logic              sw_inject,
   input logic              restart,
   input logic              data_valid,
   input logic [WORD_W-1:0] data_out,
   input logic [WORD_W-1:0] flip_mask,
   input logic [LFSR_W-1:0] lfsr_state,
   input logic [2:0]        poly_sel
);

   AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !restart |-> ((lfsr_state & poly_mask(poly_sel)) != '0));            // R1

   AST_RESTART_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !data_valid);                                            // R3

   AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !gen_en |=> !data_valid);                                            // R4

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !gen_en |=> $stable(data_out));                                      // R4

   AST_SW_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_inject && gen_en && !restart) |-> (flip_mask != '0));            // R9

   AST_SINGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(flip_mask) <= 1);                                         // R10

endmodule

bind prbs_stim_gen prbs_stim_chk #(.WORD_W(WORD_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .gen_en     (gen_en),
   .sw_inject  (sw_inject),
   .restart    (restart),
   .data_valid (data_valid),
   .data_out   (data_out),
   .flip_mask  (flip_mask),
   .lfsr_state (lfsr_state),
   .poly_sel   (poly_sel)
);

// File: tb/sim_prbs_stim_gen.sv
`timescale 1ns/1ps
module sim_prbs_stim_gen;

   localparam int W     = 16;
   localparam int NBITS = 65536;
   localparam int NWORD = NBITS / W;

   // sel, N, T, check period
   localparam int POLY_TAB [0:5][0:3] = '{
      '{0, 31, 28, 0}, '{1, 23, 18, 0}, '{2, 15, 14, 1},
      '{3, 11,  9, 1}, '{4, 10,  7, 1}, '{5,  7,  6, 1} };
   // dens_sel, ones over 127 words of the 7-bit polynomial
   localparam int DENS_TAB [0:4][0:1] = '{
      '{0, 240}, '{1, 496}, '{2, 1008}, '{3, 1520}, '{4, 1776} };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic gen_en = 1'b1;
   logic [2:0] poly_sel = 3'd5;
   logic [1:0] mode_sel = 2'd0;
   logic [2:0] dens_sel = 3'd2;
   logic [31:0] zrun_len = 32'd0;
   logic out_inv = 1'b0, ratio_en = 1'b0;
   logic [2:0] ratio_sel = 3'd0;
   logic sw_inject = 1'b0, ext_strobe = 1'b0;
   logic [W-1:0] data_out;
   logic data_valid;

   always #2 clk = ~clk;

   prbs_stim_gen #(.WORD_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .poly_sel(poly_sel),
      .mode_sel(mode_sel), .dens_sel(dens_sel), .zrun_len(zrun_len),
      .out_inv(out_inv), .ratio_en(ratio_en), .ratio_sel(ratio_sel),
      .sw_inject(sw_inject), .ext_strobe(ext_strobe),
      .data_out(data_out), .data_valid(data_valid));

   int checks = 0, errors = 0, cap_n = 0;
   bit cap [0:NBITS-1];
   bit mdl [0:NBITS-1];

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      if (data_valid && cap_n < NWORD) begin
         for (int b = 0; b < W; b++) cap[cap_n*W + b] = data_out[W-1-b];
         cap_n++;
      end
   endtask

   task automatic run_words(input int n);
      while (cap_n < n) tick();
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      tick(); tick();
      chk(!data_valid && data_out == '0, "R3", "reset state", data_out, 0);
      cap_n = 0;
      rst_n = 1'b1;
   endtask

   // Fibonacci model: new = r[N-1]^r[T-1], shift in at r[0], emit ~new
   task automatic model(input int n, input int t);
      logic [30:0] s;
      logic fb;
      s = '1;
      for (int i = 0; i < NBITS; i++) begin
         fb = s[n-1] ^ s[t-1];
         mdl[i] = ~fb;
         s = {s[29:0], fb};
      end
   endtask

   function automatic int diff_cnt(input int from, input int to);
      int d = 0;
      for (int i = from; i < to; i++) if (cap[i] != mdl[i]) d++;
      return d;
   endfunction

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired actual 1 expected 0");
      finish_run();
   end

   initial begin
      int d, ones, w, longest, run;
      // polynomial table: model match, period, ones per period (R1)
      for (int e = 0; e < 6; e++) begin
         poly_sel = 3'(POLY_TAB[e][0]);
         mode_sel = 2'd0;
         do_reset();
         run_words(NWORD);
         model(POLY_TAB[e][1], POLY_TAB[e][2]);
         d = diff_cnt(0, NBITS);
         chk(d == 0, "R1", $sformatf("model mismatch poly %0d", e), d, 0);
         if (POLY_TAB[e][3] != 0) begin
            int p;
            p = (1 << POLY_TAB[e][1]) - 1;
            d = 0; ones = 0;
            for (int i = 0; i < NBITS - p; i++) if (cap[i] != cap[i+p]) d++;
            for (int i = 0; i < p; i++) ones += int'(cap[i]);
            chk(d == 0, "R1", $sformatf("period poly %0d", e), d, 0);
            chk(ones == (1 << (POLY_TAB[e][1]-1)) - 1, "R1",
                $sformatf("ones per period poly %0d", e), ones,
                (1 << (POLY_TAB[e][1]-1)) - 1);
         end
      end

      // polarity (R2)
      poly_sel = 3'd5; out_inv = 1'b1;
      do_reset(); run_words(8); model(7, 6);
      d = 0;
      for (int i = 0; i < 8*W; i++) if (cap[i] == mdl[i]) d++;
      chk(d == 0, "R2", "inverted polarity", d, 0);
      out_inv = 1'b0;

      // stalls (R4)
      poly_sel = 3'd4;
      do_reset();
      begin
         logic [W-1:0] last;
         int viol;
         viol = 0; last = data_out;
         for (int i = 0; i < 60; i++) begin
            gen_en = (i % 3 != 1);
            tick();
            if (!gen_en && (data_valid || data_out != last)) viol++;
            last = data_out;
         end
         chk(viol == 0, "R4", "stall holds output", viol, 0);
      end
      gen_en = 1'b1;
      model(10, 7);
      d = diff_cnt(0, cap_n*W);
      chk(d == 0 && cap_n > 30, "R4", "no bit skipped across stalls", d, 0);

      // restart on polynomial change (R3)
      poly_sel = 3'd3;
      do_reset(); run_words(5);
      poly_sel = 3'd5; cap_n = 0;
      tick();
      chk(!data_valid, "R3", "restart gap", data_valid, 0);
      run_words(8); model(7, 6);
      d = diff_cnt(0, 8*W);
      chk(d == 0, "R3", "sequence restarts from seed", d, 0);

      // zero substitution (R5, R6)
      mode_sel = 2'd1; zrun_len = 32'd20;
      do_reset(); run_words(20);
      d = 0;
      for (int i = 0; i < 20*W; i++) begin
         bit ex;
         ex = ((i % 127) < 20) ? 1'b0 : ((i % 127) == 20) ? 1'b1 : mdl[i];
         if (cap[i] != ex) d++;
      end
      chk(d == 0, "R5", "zero run of 20 each period", d, 0);
      chk(cap[20] == 1'b1 && cap[147] == 1'b1, "R6", "one after run", cap[20], 1);
      zrun_len = 32'd126;
      do_reset(); run_words(20);
      longest = 0; run = 0;
      for (int i = 0; i < 20*W; i++) begin
         run = cap[i] ? 0 : run + 1;
         if (run > longest) longest = run;
      end
      chk(longest == 126, "R5", "longest zero run at length-1", longest, 126);
      chk(cap[126] == 1'b1 && cap[253] == 1'b1, "R6", "one after maximal run", cap[126], 1);
      zrun_len = 32'd0;
      do_reset(); run_words(20);
      d = diff_cnt(0, 20*W);
      chk(d == 0, "R5", "zero length leaves stream", d, 0);

      // mark density (R7)
      mode_sel = 2'd2;
      for (int e = 0; e < 5; e++) begin
         dens_sel = 3'(DENS_TAB[e][0]);
         do_reset(); run_words(127);
         ones = 0;
         for (int i = 0; i < 127*W; i++) ones += int'(cap[i]);
         chk(ones == DENS_TAB[e][1], "R7", $sformatf("ones density %0d", e),
             ones, DENS_TAB[e][1]);
         if (e == 0) begin
            d = 0;
            for (int j = 0; j < 64; j++)
               if (cap[j] != (mdl[3*j] & mdl[3*j+1] & mdl[3*j+2])) d++;
            chk(d == 0, "R7", "AND of three bits", d, 0);
         end
      end
      mode_sel = 2'd0; dens_sel = 3'd2;

      // fixed ratio (R8)
      ratio_en = 1'b1; ratio_sel = 3'd0;
      do_reset(); run_words(200);
      d = diff_cnt(0, 200*W);
      chk(d == 3 && cap[999] != mdl[999] && cap[1999] != mdl[1999]
          && cap[2999] != mdl[2999], "R8", "1e3 error positions", d, 3);
      ratio_sel = 3'd1;
      do_reset(); run_words(640);
      d = diff_cnt(0, 640*W);
      chk(d == 1 && cap[9999] != mdl[9999], "R8", "1e4 error position", d, 1);

      // merge with ratio error (R10)
      ratio_sel = 3'd0;
      do_reset(); run_words(62);
      sw_inject = 1'b1; tick(); sw_inject = 1'b0;
      run_words(70);
      d = diff_cnt(0, 70*W);
      chk(d == 1 && cap[999] != mdl[999], "R10", "request merged into ratio error", d, 1);
      ratio_en = 1'b0;

      // software and strobe injection (R9, R10)
      do_reset(); run_words(4);
      w = cap_n;
      sw_inject = 1'b1; tick(); sw_inject = 1'b0;
      run_words(w + 4);
      d = diff_cnt(w*W, (w+4)*W);
      chk(d == 1 && cap[w*W] != mdl[w*W], "R9", "software error at first bit", d, 1);
      w = cap_n;
      ext_strobe = 1'b1; tick(); tick(); tick(); ext_strobe = 1'b0;
      run_words(w + 5);
      d = diff_cnt(w*W, (w+5)*W);
      chk(d == 1 && cap[w*W] != mdl[w*W], "R9", "one error per strobe edge", d, 1);
      w = cap_n;
      sw_inject = 1'b1; ext_strobe = 1'b1; tick();
      sw_inject = 1'b0; ext_strobe = 1'b0;
      run_words(w + 3);
      d = diff_cnt(w*W, (w+3)*W);
      chk(d == 1, "R10", "simultaneous requests merged", d, 1);

      finish_run();
   end

endmodule